// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers level-sensitive interrupt request lines from a set of on-chip peripheral modules and selects one request to present to the CPU. Each module drives a fixed number of request lines, called sources, and owns one programmable 4-bit priority level that all of its sources share. Each source maps to its own vector number, so the service routine is entered directly for that source without polling.

A request takes part in arbitration only when its module level is strictly above the CPU's current 4-bit mask. The highest level wins, and ties go to the lowest source index. The winner is registered onto the request, vector and level outputs and held there until the CPU acknowledges it. On acknowledge the block drops the request and pulses a mask-load strobe that carries the accepted level. The CPU loads that level as its new mask, so only higher levels can interrupt the handler. Module levels are held in a small bank of 16-bit registers, each packing four module fields, reached through a plain address/data port.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every module level is 0, every register reads 0, `irq_o` is low and `mask_ld_o` is low.
- R2: Register address a holds modules 4a to 4a+3, with module 4a+k in bits [4k+3:4k]. Reads are combinational. A write to an address of 5 or more is ignored, and those addresses read 0. Bits [15:12] of address 4 belong to no module and always read 0.
- R3: A source is eligible only when its line is high and its module level is strictly greater than `cpu_mask`. A module at level 0 is never presented.
- R4: Among eligible sources, the one whose module has the highest level is presented.
- R5: Among eligible sources at the same level, including several lines of one module, the lowest global source index s = 4*module + line is presented.
- R6: When a source s is presented, `irq_vec` equals 64 + s and `irq_lvl` equals its module level. The presentation appears one clock edge after the request and mask are applied.
- R7: While `irq_o` is high and `irq_ack` is low, `irq_o`, `irq_vec` and `irq_lvl` keep their values, even if requests drop or higher requests arrive.
- R8: `irq_ack` while `irq_o` is high clears `irq_o` at that edge. It also raises `mask_ld_o` for exactly one cycle, with `mask_val_o` equal to the accepted level.
- R9: In the cycle in which `mask_ld_o` is high, no new request is loaded. The next selection uses the `cpu_mask` applied after the mask-load strobe.
- R10: `irq_ack` while `irq_o` is low has no effect: `mask_ld_o` stays low and `irq_o` stays low.
- R11: Requests are level-sensitive. A source whose line has been lowered is not presented again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 76 | Request line per source, index 4*module + line |
| reg_we | input | 1 | Priority register write strobe |
| reg_addr | input | 3 | Priority register address |
| reg_wdata | input | 16 | Priority register write data |
| reg_rdata | output | 16 | Priority register read data |
| cpu_mask | input | 4 | CPU's current interrupt mask |
| irq_ack | input | 1 | CPU acceptance of the presented request |
| irq_o | output | 1 | Interrupt request to the CPU |
| irq_vec | output | 8 | Vector of the presented source |
| irq_lvl | output | 4 | Level of the presented source |
| mask_ld_o | output | 1 | One-cycle strobe: CPU loads mask_val_o |
| mask_val_o | output | 4 | New mask value (accepted level) |

## Verification
On every cycle the assertions check the following:
- a presented level is nonzero and above the mask that was sampled;
- the outputs hold while an acknowledge is pending;
- an acknowledge produces a single mask-load pulse with the accepted level, followed by a cycle in which nothing is loaded;
- the vector lies within the source range and the selected source really has its line raised.

Whether the selected source is the correct one under the level and tie rules, and how registers map to module fields, can only be shown by the bench. It sweeps every source, every module's level boundary against the mask and many mixed request patterns, and compares each result with a model of its own.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int LVL_W = 4;
  localparam int FLD_PER_REG = 4;
  localparam int REG_W = LVL_W * FLD_PER_REG;

  typedef logic [LVL_W-1:0] lvl_t;

  // Register index holding a module's level field.
  function automatic int unsigned reg_of_mod(input int unsigned m);
    return m / FLD_PER_REG;
  endfunction

  // Bit position of a module's field inside its register.
  function automatic int unsigned lsb_of_mod(input int unsigned m);
    return (m % FLD_PER_REG) * LVL_W;
  endfunction

  // Vector for a global source index.
  function automatic int unsigned src_vector(input int unsigned base, input int unsigned s);
    return base + s;
  endfunction
endpackage

// File: rtl/irqc_prio_regs.sv
module irqc_prio_regs
  import irqc_pkg::*;
#(
  parameter int N_MOD = 19,
  parameter int AW    = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [AW-1:0]          addr,
  input  logic [REG_W-1:0]       wdata,
  output logic [REG_W-1:0]       rdata,
  output logic [N_MOD*LVL_W-1:0] mod_lvl
);
  for (genvar m = 0; m < N_MOD; m++) begin : g_fld
    localparam int unsigned RIDX = reg_of_mod(m);
    localparam int unsigned LSB  = lsb_of_mod(m);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mod_lvl[m*LVL_W +: LVL_W] <= '0;
      else if (we && addr == AW'(RIDX))
        mod_lvl[m*LVL_W +: LVL_W] <= wdata[LSB +: LVL_W];
    end
  end

  always_comb begin
    rdata = '0;
    for (int m = 0; m < N_MOD; m++) begin
      if (addr == AW'(reg_of_mod(m)))
        rdata[lsb_of_mod(m) +: LVL_W] = mod_lvl[m*LVL_W +: LVL_W];
    end
  end
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
  import irqc_pkg::*;
#(
  parameter int N_MOD = 19,
  parameter int SPM   = 4,
  parameter int IDX_W = 7
) (
  input  logic [N_MOD*SPM-1:0]   req,
  input  logic [N_MOD*LVL_W-1:0] mod_lvl,
  input  lvl_t                   mask,
  output logic                   found,
  output logic [IDX_W-1:0]       idx,
  output lvl_t                   lvl
);
  localparam int N_SRC = N_MOD * SPM;

  lvl_t             src_lvl [N_SRC];
  logic [N_SRC-1:0] elig;

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    assign src_lvl[s] = mod_lvl[(s/SPM)*LVL_W +: LVL_W];
    assign elig[s]    = req[s] && (src_lvl[s] > mask);
  end

  // Scan downward so that, on equal level, the lowest index is kept.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    lvl   = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (elig[i] && src_lvl[i] >= lvl) begin
        found = 1'b1;
        idx   = IDX_W'(i);
        lvl   = src_lvl[i];
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int N_MOD    = 19,
  parameter int SPM      = 4,
  parameter int AW       = 3,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 64,
  localparam int N_SRC   = N_MOD * SPM,
  localparam int IDX_W   = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] req_i,
  input  logic             reg_we,
  input  logic [AW-1:0]    reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic [LVL_W-1:0] cpu_mask,
  input  logic             irq_ack,
  output logic             irq_o,
  output logic [VEC_W-1:0] irq_vec,
  output logic [LVL_W-1:0] irq_lvl,
  output logic             mask_ld_o,
  output logic [LVL_W-1:0] mask_val_o
);
  logic [N_MOD*LVL_W-1:0] mod_lvl;
  logic                   arb_found;
  logic [IDX_W-1:0]       arb_idx;
  lvl_t                   arb_lvl;
  logic                   accept_ev;
  logic                   load_ev;

  irqc_prio_regs #(.N_MOD(N_MOD), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .mod_lvl(mod_lvl)
  );

  irqc_arbiter #(.N_MOD(N_MOD), .SPM(SPM), .IDX_W(IDX_W)) u_arb (
    .req(req_i), .mod_lvl(mod_lvl), .mask(cpu_mask),
    .found(arb_found), .idx(arb_idx), .lvl(arb_lvl)
  );

  assign accept_ev = irq_o && irq_ack;
  assign load_ev   = !irq_o && !mask_ld_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o      <= 1'b0;
      irq_vec    <= '0;
      irq_lvl    <= '0;
      mask_ld_o  <= 1'b0;
      mask_val_o <= '0;
    end else begin
      mask_ld_o <= 1'b0;
      if (accept_ev) begin
        irq_o      <= 1'b0;
        mask_ld_o  <= 1'b1;
        mask_val_o <= irq_lvl;
      end else if (load_ev) begin
        irq_o   <= arb_found;
        irq_vec <= VEC_W'(src_vector(VEC_BASE, 32'(arb_idx)));
        irq_lvl <= arb_lvl;
      end
    end
  end
endmodule

module prio_irq_ctrl_chk #(
  parameter int N_SRC    = 76,
  parameter int IDX_W    = 7,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] req_i,
  input logic [3:0]       cpu_mask,
  input logic             irq_ack,
  input logic             irq_o,
  input logic [VEC_W-1:0] irq_vec,
  input logic [3:0]       irq_lvl,
  input logic             mask_ld_o,
  input logic [3:0]       mask_val_o,
  input logic             arb_found,
  input logic [IDX_W-1:0] arb_idx
);
  p_above_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> (irq_lvl > $past(cpu_mask)) && (irq_lvl != 4'd0));

  p_sel_has_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    arb_found |-> req_i[arb_idx]);

  p_vec_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (irq_vec >= VEC_W'(VEC_BASE)) && (irq_vec < VEC_W'(VEC_BASE + N_SRC)));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !irq_ack) |=> irq_o && $stable(irq_vec) && $stable(irq_lvl));

  p_ack_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && irq_ack) |=> !irq_o && mask_ld_o && (mask_val_o == $past(irq_lvl)));

  p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mask_ld_o |=> !mask_ld_o);

  p_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mask_ld_o |=> !irq_o);

  p_idle_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_o && !mask_ld_o) |=> !mask_ld_o);
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(
  .N_SRC(N_SRC), .IDX_W(IDX_W), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .cpu_mask(cpu_mask),
  .irq_ack(irq_ack), .irq_o(irq_o), .irq_vec(irq_vec), .irq_lvl(irq_lvl),
  .mask_ld_o(mask_ld_o), .mask_val_o(mask_val_o),
  .arb_found(arb_found), .arb_idx(arb_idx)
);

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  localparam int NM = 19;
  localparam int NS = 76;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] req_i = '0;
  logic          reg_we = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [15:0]   reg_wdata = '0;
  logic [15:0]   reg_rdata;
  logic [3:0]    cpu_mask = '0;
  logic          irq_ack = 1'b0;
  logic          irq_o;
  logic [7:0]    irq_vec;
  logic [3:0]    irq_lvl;
  logic          mask_ld_o;
  logic [3:0]    mask_val_o;

  int n_tests = 0;
  int n_fail  = 0;
  int bprio [NM];
  logic [31:0] seed = 32'h1234_5679;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cpu_mask(cpu_mask), .irq_ack(irq_ack), .irq_o(irq_o),
    .irq_vec(irq_vec), .irq_lvl(irq_lvl), .mask_ld_o(mask_ld_o),
    .mask_val_o(mask_val_o)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  // Reference selection: search levels from the top, indices from the bottom.
  task automatic model(input logic [NS-1:0] rq, input int mk,
                       output bit f, output int ix, output int lv);
    f = 0; ix = 0; lv = 0;
    for (int l = 15; l > mk && !f; l--)
      for (int s = 0; s < NS && !f; s++)
        if (rq[s] && bprio[s/4] == l) begin f = 1; ix = s; lv = l; end
  endtask

  function automatic logic [15:0] exp_reg(input int a);
    logic [15:0] v = '0;
    for (int k = 0; k < 4; k++)
      if (a < 5 && a*4 + k < NM) v[k*4 +: 4] = 4'(bprio[a*4 + k]);
    return v;
  endfunction

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    for (int k = 0; k < 4; k++)
      if (a < 5 && a*4 + k < NM) bprio[a*4 + k] = int'(d[k*4 +: 4]);
  endtask

  task automatic rd_chk(input string tag, input int a);
    reg_addr = 3'(a);
    #1;
    chk(tag, int'(reg_rdata), int'(exp_reg(a)));
  endtask

  // Apply a pattern, check the presentation, acknowledge it if any.
  task automatic run_case(input logic [NS-1:0] rq, input int mk, input string tag);
    bit f; int ix; int lv;
    model(rq, mk, f, ix, lv);
    @(negedge clk);
    req_i = rq; cpu_mask = 4'(mk);
    @(negedge clk);
    chk({tag, " R3 irq_o"}, int'(irq_o), int'(f));
    if (f) begin
      chk({tag, " R4 R5 R6 vec"}, int'(irq_vec), 64 + ix);
      chk({tag, " R6 lvl"}, int'(irq_lvl), lv);
      irq_ack = 1'b1;
      @(negedge clk);
      irq_ack = 1'b0;
      chk({tag, " R8 drop"}, int'(irq_o), 0);
      chk({tag, " R8 strobe"}, int'(mask_ld_o), 1);
      chk({tag, " R8 mask_val"}, int'(mask_val_o), lv);
      req_i = '0;
      @(negedge clk);
      chk({tag, " R8 one cycle"}, int'(mask_ld_o), 0);
    end else begin
      req_i = '0;
    end
  endtask

  task automatic prog_ramp();
    for (int a = 0; a < 5; a++) begin
      logic [15:0] d = '0;
      for (int k = 0; k < 4; k++) d[k*4 +: 4] = 4'(((a*4 + k) % 15) + 1);
      wr(a, d);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [NS-1:0] rq;
    for (int m = 0; m < NM; m++) bprio[m] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 irq_o", int'(irq_o), 0);
    chk("R1 mask_ld", int'(mask_ld_o), 0);
    for (int a = 0; a < 8; a++) rd_chk("R1 reg", a);

    // R2: register map, out-of-range, unused field
    for (int a = 0; a < 8; a++) wr(a, 16'hA5C3 ^ 16'(a * 16'h1111));
    for (int a = 0; a < 8; a++) rd_chk("R2 readback", a);

    // R6: every source alone
    prog_ramp();
    for (int s = 0; s < NS; s++) begin
      rq = '0; rq[s] = 1'b1;
      run_case(rq, 0, "R6 sweep");
    end

    // R3: each module's level against the mask on both sides
    for (int m = 0; m < NM; m++) begin
      rq = '0; rq[m*4 + 3] = 1'b1;
      run_case(rq, bprio[m] - 1, "R3 below");
      run_case(rq, bprio[m], "R3 equal");
    end
    wr(0, 16'h5550);
    rq = '0; rq[0] = 1'b1; rq[3] = 1'b1;
    run_case(rq, 0, "R3 level0");
    @(negedge clk);
    chk("R3 level0 idle", int'(irq_o), 0);

    // R5: ties inside one module and across modules
    wr(2, 16'h0333);
    rq = '0; rq[9] = 1'b1; rq[11] = 1'b1;
    run_case(rq, 0, "R5 same module");
    rq = '0; rq[15] = 1'b1; rq[5] = 1'b1;
    run_case(rq, 0, "R5 across");
    rq = '0; rq[15] = 1'b1; rq[1] = 1'b1;
    run_case(rq, 0, "R4 higher wins");

    // R7: hold while not acknowledged
    prog_ramp();
    @(negedge clk);
    req_i = '0; req_i[8] = 1'b1; cpu_mask = 4'd0;
    @(negedge clk);
    chk("R7 first vec", int'(irq_vec), 72);
    req_i = '0; req_i[60] = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 hold irq", int'(irq_o), 1);
    chk("R7 hold vec", int'(irq_vec), 72);
    chk("R7 hold lvl", int'(irq_lvl), 3);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0; req_i = '0;
    repeat (2) @(negedge clk);

    // R9: no load in the strobe cycle, then the new mask rules
    req_i = '0; req_i[4] = 1'b1; req_i[40] = 1'b1;
    @(negedge clk);
    chk("R9 first vec", int'(irq_vec), 104);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    chk("R9 strobe", int'(mask_ld_o), 1);
    req_i[40] = 1'b0;
    @(negedge clk);
    chk("R9 gap", int'(irq_o), 0);
    @(negedge clk);
    chk("R9 next irq", int'(irq_o), 1);
    chk("R9 next vec", int'(irq_vec), 68);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0; req_i = '0;
    repeat (2) @(negedge clk);

    // R10: acknowledge while idle
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    chk("R10 no strobe", int'(mask_ld_o), 0);
    chk("R10 no irq", int'(irq_o), 0);

    // R11: lowered line is not presented again
    rq = '0; rq[20] = 1'b1;
    run_case(rq, 0, "R11 once");
    repeat (3) @(negedge clk);
    chk("R11 gone", int'(irq_o), 0);

    // R4 R5: mixed patterns with reprogrammed levels
    for (int it = 0; it < 400; it++) begin
      if (it % 25 == 0)
        for (int a = 0; a < 5; a++) wr(a, 16'(rnd()));
      rq = NS'({rnd(), rnd(), rnd()} & {rnd(), rnd(), rnd()});
      run_case(rq, int'(rnd() % 16), "R4 R5 mix");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule